// File: doc/BRIEF.md
# Page-One Stack Pointer Unit

This block holds an 8-bit stack pointer and turns single-byte and two-byte stack requests into memory accesses. The stack sits in one fixed 256-byte page of a 16-bit address space. The page byte is 0x01 by default, so the stack spans 0x0100 to 0x01FF. The pointer always names the next free byte. Saving a byte writes at the pointer and then moves the pointer down. Restoring a byte moves the pointer up and then reads.

A processor core places one request per cycle on `req_op` together with `req_valid`. There are five requests:

- push one byte;
- pull one byte;
- copy the X register into the pointer;
- save a 16-bit return address;
- restore a 16-bit return address.

The two-byte requests take two cycles. For both of them, `busy` is high in the second cycle. Pulled bytes and restored addresses come back on registered outputs one cycle after the last read. The memory itself sits outside the block. It has a write strobe and an asynchronous read port.

Top module: `stack_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the pointer becomes 0xFF. After that edge `busy`, `mem_we`, `pull_valid` and `ret_valid` are 0.
- R2: Every write goes to `{0x01, sp}`: the high address byte is fixed and the low byte is the current pointer.
- R3: A push request (`req_op`=1) writes `req_data` at the current pointer in the same cycle. The pointer then drops by one.
- R4: A pull request (`req_op`=2) reads at pointer+1 and moves the pointer up by one. The byte read appears on `pull_data` with `pull_valid` high for one cycle, in the cycle after the request.
- R5: The pointer wraps between 0x00 and 0xFF in both directions, and nothing signals the wrap.
- R6: The only way to load the pointer is a transfer request (`req_op`=3). It copies `x_in` into the pointer at the next edge.
- R7: A call request (`req_op`=4) writes `req_addr[15:8]` at the pointer in the request cycle. It writes `req_addr[7:0]` one below that in the next cycle. The pointer falls by two, and `busy` is high only in the second cycle.
- R8: A return request (`req_op`=5) reads the low byte at pointer+1 and then the high byte at pointer+2. The pointer rises by two. `ret_addr` with `ret_valid` appears in the cycle after the second read.
- R9: Any request presented while `busy` is high is ignored: it causes no write, no pointer change and no result.
- R10: Operation codes 0, 6 and 7 do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Operation code (1 push, 2 pull, 3 load from X, 4 call, 5 return) |
| req_data | input | 8 | Byte to push |
| req_addr | input | 16 | Return address to save on a call |
| x_in | input | 8 | X register value for the transfer |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | 8 | Asynchronous read data from memory |
| pull_data | output | 8 | Byte from the last pull |
| pull_valid | output | 1 | pull_data is valid for this cycle |
| ret_addr | output | 16 | Restored return address |
| ret_valid | output | 1 | ret_addr is valid for this cycle |
| busy | output | 1 | Second cycle of a two-byte sequence |
| sp | output | 8 | Current stack pointer |

## Verification
The first pattern is runs of pushes followed by pulls of the same depth. These show whether the stack is last-in first-out and whether the pointer moves before or after each access. Loading the pointer near 0x00 and then pushing and pulling across the boundary separates correct silent wrap from a clamped or flagged pointer. A call followed by a return of the same address uses a value whose two bytes differ, so a swapped byte order shows up as a wrong address. Requests issued during `busy`, and reserved op codes, are observed at the write port and on `sp` to confirm that they have no effect.

// File: rtl/stk_pkg.sv
package stk_pkg;

    localparam int unsigned PTR_W  = 8;
    localparam int unsigned ADDR_W = 16;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_PUSH  = 3'd1,
        OP_PULL  = 3'd2,
        OP_LOADX = 3'd3,
        OP_CALL  = 3'd4,
        OP_RET   = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CALL_LO = 2'd1,
        ST_RET_HI  = 2'd2
    } seq_e;

    typedef enum logic [1:0] {
        WS_DATA = 2'd0,
        WS_HI   = 2'd1,
        WS_LO   = 2'd2
    } wsel_e;

    typedef struct packed {
        logic  inc;
        logic  dec;
        logic  load;
        logic  we;
        wsel_e wsel;
        logic  cap_pull;
        logic  cap_call_lo;
        logic  cap_ret_lo;
        logic  cap_ret_hi;
    } ctl_t;

    function automatic logic [ADDR_W-1:0] page_addr(input logic [ADDR_W-PTR_W-1:0] pg,
                                                    input logic [PTR_W-1:0] low);
        return {pg, low};
    endfunction

endpackage

// File: rtl/stk_ptr.sv
module stk_ptr #(
    parameter int unsigned W   = 8,
    parameter logic [W-1:0] RST = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         dec,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst)       ptr <= RST;
        else if (load) ptr <= load_val;
        else if (inc)  ptr <= ptr + W'(1);
        else if (dec)  ptr <= ptr - W'(1);
    end
endmodule

// File: rtl/stk_seq.sv
module stk_seq
    import stk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic [2:0] req_op,
    output ctl_t       ctl,
    output logic       busy
);
    seq_e state, state_nx;

    always_comb begin
        ctl      = '0;
        ctl.wsel = WS_DATA;
        state_nx = state;
        unique case (state)
            ST_CALL_LO: begin
                ctl.we   = 1'b1;
                ctl.wsel = WS_LO;
                ctl.dec  = 1'b1;
                state_nx = ST_IDLE;
            end
            ST_RET_HI: begin
                ctl.inc        = 1'b1;
                ctl.cap_ret_hi = 1'b1;
                state_nx       = ST_IDLE;
            end
            default: begin
                if (req_valid) begin
                    case (req_op)
                        OP_PUSH: begin
                            ctl.we  = 1'b1;
                            ctl.dec = 1'b1;
                        end
                        OP_PULL: begin
                            ctl.inc      = 1'b1;
                            ctl.cap_pull = 1'b1;
                        end
                        OP_LOADX: ctl.load = 1'b1;
                        OP_CALL: begin
                            ctl.we          = 1'b1;
                            ctl.wsel        = WS_HI;
                            ctl.dec         = 1'b1;
                            ctl.cap_call_lo = 1'b1;
                            state_nx        = ST_CALL_LO;
                        end
                        OP_RET: begin
                            ctl.inc        = 1'b1;
                            ctl.cap_ret_lo = 1'b1;
                            state_nx       = ST_RET_HI;
                        end
                        default: ;
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    assign busy = (state != ST_IDLE);
endmodule

// File: rtl/stk_data.sv
module stk_data
    import stk_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  ctl_t          ctl,
    input  logic [DW-1:0] req_data,
    input  logic [2*DW-1:0] req_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] wdata,
    output logic [DW-1:0] pull_data,
    output logic          pull_valid,
    output logic [2*DW-1:0] ret_addr,
    output logic          ret_valid
);
    logic [DW-1:0] call_lo_q;
    logic [DW-1:0] ret_lo_q;

    always_comb begin
        unique case (ctl.wsel)
            WS_HI:   wdata = req_addr[2*DW-1:DW];
            WS_LO:   wdata = call_lo_q;
            default: wdata = req_data;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            call_lo_q  <= '0;
            ret_lo_q   <= '0;
            pull_data  <= '0;
            pull_valid <= 1'b0;
            ret_addr   <= '0;
            ret_valid  <= 1'b0;
        end else begin
            pull_valid <= ctl.cap_pull;
            ret_valid  <= ctl.cap_ret_hi;
            if (ctl.cap_call_lo) call_lo_q <= req_addr[DW-1:0];
            if (ctl.cap_ret_lo)  ret_lo_q  <= mem_rdata;
            if (ctl.cap_pull)    pull_data <= mem_rdata;
            if (ctl.cap_ret_hi)  ret_addr  <= {mem_rdata, ret_lo_q};
        end
    end
endmodule

// File: rtl/stack_unit.sv
module stack_unit
    import stk_pkg::*;
#(
    parameter logic [ADDR_W-PTR_W-1:0] PAGE    = 8'h01,
    parameter logic [PTR_W-1:0]        RST_PTR = 8'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [PTR_W-1:0]  req_data,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [PTR_W-1:0]  x_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [PTR_W-1:0]  mem_wdata,
    output logic              mem_we,
    input  logic [PTR_W-1:0]  mem_rdata,
    output logic [PTR_W-1:0]  pull_data,
    output logic              pull_valid,
    output logic [ADDR_W-1:0] ret_addr,
    output logic              ret_valid,
    output logic              busy,
    output logic [PTR_W-1:0]  sp
);
    ctl_t ctl;

    stk_seq u_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .ctl(ctl), .busy(busy)
    );

    stk_ptr #(.W(PTR_W), .RST(RST_PTR)) u_ptr (
        .clk(clk), .rst(rst), .inc(ctl.inc), .dec(ctl.dec),
        .load(ctl.load), .load_val(x_in), .ptr(sp)
    );

    stk_data #(.DW(PTR_W)) u_data (
        .clk(clk), .rst(rst), .ctl(ctl), .req_data(req_data),
        .req_addr(req_addr), .mem_rdata(mem_rdata), .wdata(mem_wdata),
        .pull_data(pull_data), .pull_valid(pull_valid),
        .ret_addr(ret_addr), .ret_valid(ret_valid)
    );

    // writes land on the pointer, reads on the byte above it
    assign mem_we   = ctl.we;
    assign mem_addr = page_addr(PAGE, ctl.we ? sp : sp + PTR_W'(1));
endmodule

// File: rtl/stack_unit_chk.sv
module stack_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [2:0]  req_op,
    input logic [7:0]  x_in,
    input logic [15:0] mem_addr,
    input logic        mem_we,
    input logic        pull_valid,
    input logic        busy,
    input logic [7:0]  sp
);
    wire take = req_valid && !busy;

    assert_page_one_R2: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr[15:8] == 8'h01 && mem_addr[7:0] == sp));

    assert_write_moves_down_R3: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (sp == $past(sp) - 8'd1));

    assert_pull_result_R4: assert property (@(posedge clk) disable iff (rst)
        (take && req_op == 3'd2) |=> pull_valid);

    assert_load_from_x_R6: assert property (@(posedge clk) disable iff (rst)
        (take && req_op == 3'd3) |=> (sp == $past(x_in)));

    assert_busy_single_R7: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy);
endmodule

bind stack_unit stack_unit_chk u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .x_in(x_in), .mem_addr(mem_addr), .mem_we(mem_we),
    .pull_valid(pull_valid), .busy(busy), .sp(sp)
);

// File: tb/tb_stack_unit.sv
module tb_stack_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = 3'd0;
    logic [7:0]  req_data = 8'h00;
    logic [15:0] req_addr = 16'h0000;
    logic [7:0]  x_in = 8'h00;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic [7:0]  mem_rdata;
    logic [7:0]  pull_data;
    logic        pull_valid;
    logic [15:0] ret_addr;
    logic        ret_valid;
    logic        busy;
    logic [7:0]  sp;

    always #2.5 clk = ~clk;

    stack_unit dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_data(req_data), .req_addr(req_addr), .x_in(x_in),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_rdata(mem_rdata), .pull_data(pull_data), .pull_valid(pull_valid),
        .ret_addr(ret_addr), .ret_valid(ret_valid), .busy(busy), .sp(sp)
    );

    // page-one memory
    logic [7:0] pg [256];
    initial for (int i = 0; i < 256; i++) pg[i] = 8'h00;
    assign mem_rdata = pg[mem_addr[7:0]];
    always @(posedge clk) if (mem_we) pg[mem_addr[7:0]] <= mem_wdata;

    // reference model
    logic [7:0] m_sp;
    logic [7:0] m_mem [256];
    initial for (int i = 0; i < 256; i++) m_mem[i] = 8'h00;

    logic [23:0] q_wr [$];
    logic [7:0]  q_pull [$];
    logic [15:0] q_ret [$];

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: compares outputs with scoreboard queues
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (!rst && mem_we) begin
                if (q_wr.size() == 0) check("R9 unexpected write", {8'h0, mem_addr, mem_wdata}, 32'hFFFFFFFF);
                else begin
                    logic [23:0] e;
                    e = q_wr.pop_front();
                    check("R2/R3/R7 write", {8'h0, mem_addr, mem_wdata}, {8'h0, e});
                end
            end
            if (!rst && pull_valid) begin
                if (q_pull.size() == 0) check("R4 unexpected pull", {24'h0, pull_data}, 32'hFFFFFFFF);
                else check("R4/R5 pull data", {24'h0, pull_data}, {24'h0, q_pull.pop_front()});
            end
            if (!rst && ret_valid) begin
                if (q_ret.size() == 0) check("R8 unexpected return", {16'h0, ret_addr}, 32'hFFFFFFFF);
                else check("R8 return address", {16'h0, ret_addr}, {16'h0, q_ret.pop_front()});
            end
        end
    end

    // driver: updates the model and queues expected results
    task automatic model(input logic [2:0] op, input logic [7:0] d, input logic [15:0] a, input logic [7:0] x);
        case (op)
            3'd1: begin q_wr.push_back({8'h01, m_sp, d}); m_mem[m_sp] = d; m_sp = m_sp - 8'd1; end
            3'd2: begin m_sp = m_sp + 8'd1; q_pull.push_back(m_mem[m_sp]); end
            3'd3: m_sp = x;
            3'd4: begin
                q_wr.push_back({8'h01, m_sp, a[15:8]}); m_mem[m_sp] = a[15:8]; m_sp = m_sp - 8'd1;
                q_wr.push_back({8'h01, m_sp, a[7:0]});  m_mem[m_sp] = a[7:0];  m_sp = m_sp - 8'd1;
            end
            3'd5: begin
                logic [7:0] lo, hi;
                m_sp = m_sp + 8'd1; lo = m_mem[m_sp];
                m_sp = m_sp + 8'd1; hi = m_mem[m_sp];
                q_ret.push_back({hi, lo});
            end
            default: ;
        endcase
    endtask

    task automatic issue(input logic [2:0] op, input logic [7:0] d, input logic [15:0] a, input logic [7:0] x);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_data = d; req_addr = a; x_in = x;
        model(op, d, a, x);
        @(negedge clk);
        req_valid = 1'b0; req_op = 3'd0;
        if (op == 3'd4 || op == 3'd5) @(negedge clk);
    endtask

    // two-cycle request with a second request held during busy
    task automatic issue_with_intruder(input logic [2:0] op, input logic [15:0] a,
                                       input logic [2:0] op2, input logic [7:0] d2, input logic [7:0] x2);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a;
        model(op, 8'h00, a, 8'h00);
        @(negedge clk);
        check("R7 busy in second cycle", {31'h0, busy}, 32'd1);
        req_op = op2; req_data = d2; x_in = x2;
        @(negedge clk);
        req_valid = 1'b0; req_op = 3'd0;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        if (!done) begin
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        m_sp = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1 sp after reset", {24'h0, sp}, 32'hFF);
        check("R1 busy after reset", {31'h0, busy}, 32'd0);
        check("R1 no write after reset", {31'h0, mem_we}, 32'd0);
        check("R1 no results after reset", {30'h0, pull_valid, ret_valid}, 32'd0);

        // R3 pushes, then R4 pulls (LIFO)
        issue(3'd1, 8'h11, 16'h0, 8'h0);
        issue(3'd1, 8'h22, 16'h0, 8'h0);
        issue(3'd1, 8'h33, 16'h0, 8'h0);
        #1 check("R3 sp after three pushes", {24'h0, sp}, 32'hFC);
        issue(3'd2, 8'h0, 16'h0, 8'h0);
        issue(3'd2, 8'h0, 16'h0, 8'h0);
        #1 check("R4 sp after two pulls", {24'h0, sp}, 32'hFE);
        issue(3'd2, 8'h0, 16'h0, 8'h0);
        #1 check("R4 sp back at top", {24'h0, sp}, 32'hFF);

        // R6 load and R5 wrap on push
        issue(3'd3, 8'h0, 16'h0, 8'h01);
        #1 check("R6 sp loaded from X", {24'h0, sp}, 32'h01);
        issue(3'd1, 8'hA1, 16'h0, 8'h0);
        issue(3'd1, 8'hB2, 16'h0, 8'h0);
        #1 check("R5 push wraps 00 to FF", {24'h0, sp}, 32'hFF);
        issue(3'd1, 8'hC3, 16'h0, 8'h0);
        // R5 wrap on pull
        issue(3'd2, 8'h0, 16'h0, 8'h0);
        issue(3'd2, 8'h0, 16'h0, 8'h0);
        #1 check("R5 pull wraps FF to 00", {24'h0, sp}, 32'h00);
        issue(3'd2, 8'h0, 16'h0, 8'h0);

        // R7 call and R8 return
        issue(3'd3, 8'h0, 16'h0, 8'hF0);
        issue(3'd4, 8'h0, 16'hC0DE, 8'h0);
        #1 check("R7 sp after call", {24'h0, sp}, 32'hEE);
        issue(3'd4, 8'h0, 16'h1234, 8'h0);
        issue(3'd5, 8'h0, 16'h0, 8'h0);
        issue(3'd5, 8'h0, 16'h0, 8'h0);
        #1 check("R8 sp after returns", {24'h0, sp}, 32'hF0);

        // R9 requests during busy are ignored
        issue_with_intruder(3'd4, 16'hBEEF, 3'd1, 8'h77, 8'h00);
        #1 check("R9 push ignored during call", {24'h0, sp}, 32'hEE);
        issue_with_intruder(3'd5, 16'h0, 3'd3, 8'h00, 8'h40);
        #1 check("R9 load ignored during return", {24'h0, sp}, 32'hF0);

        // R10 reserved codes do nothing
        issue(3'd6, 8'h55, 16'h0, 8'h10);
        issue(3'd7, 8'h55, 16'h0, 8'h10);
        issue(3'd0, 8'h55, 16'h0, 8'h10);
        #1 check("R10 reserved codes leave sp", {24'h0, sp}, 32'hF0);

        repeat (3) @(negedge clk);
        check("R3/R7 all writes seen", q_wr.size(), 0);
        check("R4 all pulls seen", q_pull.size(), 0);
        check("R8 all returns seen", q_ret.size(), 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule